// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the serial-side front end of a 16K x 8 nonvolatile memory. It acts as a mode-0 serial peripheral slave. The chip-select, serial clock, serial data in and pause (hold) pins are sampled as ordinary synchronous inputs on the system clock. Each framed transfer starts with an 8-bit instruction. Depending on that instruction, a 16-bit byte address and data bytes follow. Status or array data is returned on a serial output that has its own output-enable.

Six instructions are recognised: set write latch, clear write latch, status read, status write, array read and array write. The front end does no protection or programming itself. It passes single-cycle strobes to a protection unit (latch set/clear, status write) and to a page write controller (one strobe per data byte, plus a commit strobe when chip select is released). It reads the write latch, busy flag, protect-enable and block-protect bits back from those units to form the status byte and to gate requests.

Top module: `ee_spi_front`

## Requirements
- R1: After reset, and at any time while `cs_ni` is high, `so_oe_o` is low and no strobe fires, whatever `sck_i` and `si_i` do.
- R2: Bits are shifted in MSB first on rising `sck_i`. The instruction byte is decoded with bit 3 ignored. 0000_x110 pulses `wel_set_o` and 0000_x100 pulses `wel_clr_o`.
- R3: An instruction whose upper nibble is nonzero, or whose low three bits are 000 or 111, produces no strobe. The rest of that transfer is ignored and the output stays disabled until chip select is raised.
- R4: 0000_x101 returns the status byte {wpen_i, 3'b000, bp_i[1], bp_i[0], wel_i, 1'b0}. It goes out MSB first on falling `sck_i` and repeats for every further byte. Its first bit appears on the falling edge after the eighth instruction bit.
- R5: While `busy_i` is high, the status byte reads 8'hFF and every instruction other than status read locks the transfer with no strobe and no output.
- R6: 0000_x011 is followed by a 16-bit address whose bits 15 and 14 are ignored. Data from `rd_data_i` is then streamed out, starting on the falling edge after the last address bit. The 14-bit address advances after each byte and wraps from 3FFF to 0000.
- R7: 0000_x010 is accepted only when `wel_i` is high; otherwise the transfer is ignored. Each complete data byte pulses `wr_byte_o` with its address and data. Only the low 5 address bits advance, wrapping inside a 32-byte page.
- R8: `wr_commit_o` pulses once when chip select rises after an accepted write that received at least one complete data byte and ended on a byte boundary. Otherwise it does not pulse.
- R9: 0000_x001 with `wel_i` high pulses `sr_wr_o` with the first data byte on `sr_data_o`, and ignores any further bytes. With `wel_i` low there is no strobe.
- R10: `hold_ni` is taken or released only while `sck_i` is low. While held, the output is disabled, clock edges are ignored and the bit position is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, sampled |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for `so_o` |
| busy_i | input | 1 | Internal programming cycle in progress |
| wel_i | input | 1 | Write latch state |
| wpen_i | input | 1 | Protect-enable status bit |
| bp_i | input | 2 | Block-protect status bits |
| rd_addr_o | output | 14 | Array read address |
| rd_data_i | input | 8 | Array read data for `rd_addr_o` |
| wel_set_o | output | 1 | Set write latch strobe |
| wel_clr_o | output | 1 | Clear write latch strobe |
| sr_wr_o | output | 1 | Status write strobe |
| sr_data_o | output | 8 | Status write byte |
| wr_byte_o | output | 1 | Page data byte strobe |
| wr_addr_o | output | 14 | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | Start programming strobe |

## Verification
A table of instruction bytes is applied: valid codes with bit 3 clear and set, codes with a nonzero upper nibble, and the unused codes 000 and 111, each with the busy and latch inputs set both ways. This separates a correct decode from one that looks at bit 3, accepts invalid codes, or ignores busy. Array reads start two bytes below the top address, with bits 15:14 set, so that wrap and don't-care handling appear in the returned data. Writes start at a page's last byte, with high address bits set, so that a page wrap is told apart from a full increment. Hold is exercised in the middle of an instruction and in the middle of an output byte, with clock toggles and junk input during the pause; a lost bit position would corrupt the decode or the byte.

// File: rtl/ee_spi_pkg.sv
package ee_spi_pkg;
  typedef enum logic [2:0] {PH_OPC, PH_ADR, PH_DIN, PH_OUT, PH_LOCK} phase_e;
  typedef enum logic [2:0] {CMD_NONE, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_WRITE} cmd_e;

  localparam logic [2:0] OP_SET_LATCH = 3'b110;
  localparam logic [2:0] OP_CLR_LATCH = 3'b100;
  localparam logic [2:0] OP_RD_STAT   = 3'b101;
  localparam logic [2:0] OP_WR_STAT   = 3'b001;
  localparam logic [2:0] OP_RD_ARRAY  = 3'b011;
  localparam logic [2:0] OP_WR_ARRAY  = 3'b010;
endpackage

// File: rtl/ee_spi_sampler.sv
module ee_spi_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_rise_o,
  output logic holding_o
);
  logic sck_q, cs_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_ni)       hold_q <= 1'b0;
      else if (!sck_i) hold_q <= !hold_ni;  // pause changes only with clock low
    end
  end

  assign sck_rise_o = !cs_ni && !hold_q &&  sck_i && !sck_q;
  assign sck_fall_o = !cs_ni && !hold_q && !sck_i &&  sck_q;
  assign cs_rise_o  = cs_ni && !cs_q;
  assign holding_o  = hold_q;
endmodule

// File: rtl/ee_spi_outshift.sv
module ee_spi_outshift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] load_i,
  output logic              so_o,
  output logic              active_o,
  output logic              byte_done_o
);
  localparam int CW = $clog2(BYTE_W);

  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-2:0] sh_q;
  logic              so_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      so_q  <= 1'b0;
      act_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      so_q  <= 1'b0;
    end else if (shift_i) begin
      act_q <= 1'b1;
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == '0) {so_q, sh_q} <= load_i;
      else             {so_q, sh_q} <= {sh_q, 1'b0};
    end
  end

  assign so_o        = so_q;
  assign active_o    = act_q;
  assign byte_done_o = shift_i && (cnt_q == CW'(BYTE_W - 1));
endmodule

// File: rtl/ee_spi_front.sv
module ee_spi_front
  import ee_spi_pkg::*;
#(
  parameter int MEM_AW  = 14,
  parameter int ADR_BITS = 16,
  parameter int PAGE_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              hold_ni,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic              busy_i,
  input  logic              wel_i,
  input  logic              wpen_i,
  input  logic [1:0]        bp_i,
  output logic [MEM_AW-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wel_set_o,
  output logic              wel_clr_o,
  output logic              sr_wr_o,
  output logic [7:0]        sr_data_o,
  output logic              wr_byte_o,
  output logic [MEM_AW-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o
);
  localparam int CNT_W = $clog2(ADR_BITS);

  logic sck_rise, sck_fall, cs_rise, holding;
  logic out_active, byte_done, shift_out;
  logic [7:0] status, load_byte, in_bit;

  phase_e            phase_q;
  cmd_e              cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [6:0]        in_sh_q;
  logic [MEM_AW-1:0] addr_q;
  logic              byte_seen_q, oe_q;
  logic              set_q, clr_q, srw_q, wrb_q, cmt_q;
  logic [7:0]        sr_data_q, wr_data_q;
  logic [MEM_AW-1:0] wr_addr_q;

  ee_spi_sampler u_smp (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .hold_ni,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_rise_o(cs_rise), .holding_o(holding)
  );

  assign status    = busy_i ? 8'hFF : {wpen_i, 3'b000, bp_i, wel_i, 1'b0};
  assign load_byte = (cmd_q == CMD_RDSR) ? status : rd_data_i;
  assign shift_out = sck_fall && (phase_q == PH_OUT);
  assign in_bit    = {in_sh_q, si_i};

  ee_spi_outshift #(.BYTE_W(8)) u_out (
    .clk_i, .rst_ni,
    .clear_i(cs_ni), .shift_i(shift_out), .load_i(load_byte),
    .so_o(so_o), .active_o(out_active), .byte_done_o(byte_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OPC;  cmd_q <= CMD_NONE;  cnt_q <= '0;
      in_sh_q <= '0;      addr_q <= '0;       byte_seen_q <= 1'b0;
      oe_q <= 1'b0;
      set_q <= 1'b0; clr_q <= 1'b0; srw_q <= 1'b0; wrb_q <= 1'b0; cmt_q <= 1'b0;
      sr_data_q <= '0; wr_data_q <= '0; wr_addr_q <= '0;
    end else begin
      set_q <= 1'b0; clr_q <= 1'b0; srw_q <= 1'b0; wrb_q <= 1'b0;
      cmt_q <= cs_rise && (cmd_q == CMD_WRITE) && (phase_q == PH_DIN)
               && byte_seen_q && (cnt_q == '0);
      oe_q  <= !cs_ni && !holding && out_active;
      if (cs_ni) begin
        phase_q <= PH_OPC; cmd_q <= CMD_NONE; cnt_q <= '0; byte_seen_q <= 1'b0;
      end else if (sck_rise) begin
        unique case (phase_q)
          PH_OPC: begin
            in_sh_q <= in_bit[6:0];
            cnt_q   <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(7)) begin
              cnt_q   <= '0;
              phase_q <= PH_LOCK;
              if (in_bit[7:4] == 4'h0 && !(busy_i && in_bit[2:0] != OP_RD_STAT)) begin
                unique case (in_bit[2:0])
                  OP_SET_LATCH: set_q <= 1'b1;
                  OP_CLR_LATCH: clr_q <= 1'b1;
                  OP_RD_STAT:   begin cmd_q <= CMD_RDSR; phase_q <= PH_OUT; end
                  OP_WR_STAT:   if (wel_i) begin cmd_q <= CMD_WRSR; phase_q <= PH_DIN; end
                  OP_RD_ARRAY:  begin cmd_q <= CMD_READ; phase_q <= PH_ADR; end
                  OP_WR_ARRAY:  if (wel_i) begin cmd_q <= CMD_WRITE; phase_q <= PH_ADR; end
                  default: ;
                endcase
              end
            end
          end
          PH_ADR: begin
            addr_q <= {addr_q[MEM_AW-2:0], si_i};  // upper bits fall off
            cnt_q  <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(ADR_BITS - 1)) begin
              cnt_q   <= '0;
              phase_q <= (cmd_q == CMD_READ) ? PH_OUT : PH_DIN;
            end
          end
          PH_DIN: begin
            in_sh_q <= in_bit[6:0];
            cnt_q   <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(7)) begin
              cnt_q <= '0;
              if (cmd_q == CMD_WRSR) begin
                srw_q     <= 1'b1;
                sr_data_q <= in_bit;
                phase_q   <= PH_LOCK;
              end else begin
                wrb_q       <= 1'b1;
                wr_data_q   <= in_bit;
                wr_addr_q   <= addr_q;
                byte_seen_q <= 1'b1;
                addr_q[PAGE_AW-1:0] <= addr_q[PAGE_AW-1:0] + PAGE_AW'(1);
              end
            end
          end
          default: ;
        endcase
      end else if (byte_done && cmd_q == CMD_READ) begin
        addr_q <= addr_q + MEM_AW'(1);
      end
    end
  end

  assign so_oe_o     = oe_q;
  assign rd_addr_o   = addr_q;
  assign wel_set_o   = set_q;
  assign wel_clr_o   = clr_q;
  assign sr_wr_o     = srw_q;
  assign sr_data_o   = sr_data_q;
  assign wr_byte_o   = wrb_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign wr_commit_o = cmt_q;
endmodule

// File: rtl/ee_spi_front_chk.sv
module ee_spi_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic busy_i,
  input logic so_oe_o,
  input logic wel_set_o,
  input logic wel_clr_o,
  input logic sr_wr_o,
  input logic wr_byte_o,
  input logic wr_commit_o
);
  a_r1_hiz_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !so_oe_o);

  a_r2_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wel_set_o, wel_clr_o, sr_wr_o, wr_byte_o, wr_commit_o}));

  a_r5_no_set_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_set_o |-> !$past(busy_i));

  a_r8_commit_on_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> $past(cs_ni));
endmodule

bind ee_spi_front ee_spi_front_chk u_chk (.*);

// File: tb/ee_spi_front_test.sv
module ee_spi_front_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck_i = 1'b0, si_i = 1'b0, hold_ni = 1'b1;
  logic busy_i = 1'b0, wel_i = 1'b0, wpen_i = 1'b1;
  logic [1:0] bp_i = 2'b10;
  logic so_o, so_oe_o, wel_set_o, wel_clr_o, sr_wr_o, wr_byte_o, wr_commit_o;
  logic [13:0] rd_addr_o, wr_addr_o;
  logic [7:0] rd_data_i, sr_data_o, wr_data_o;

  int n_vec = 0, n_bad = 0;
  int n_set = 0, n_clr = 0, n_sr = 0, n_wr = 0, n_cm = 0;
  logic [7:0]  last_sr = '0;
  logic [13:0] wa [0:7];
  logic [7:0]  wd [0:7];

  always #5 clk_i = ~clk_i;

  function automatic logic [7:0] mem_f(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01};
  endfunction
  assign rd_data_i = mem_f(rd_addr_o);

  ee_spi_front uut (.*);

  always @(posedge clk_i) begin
    if (wel_set_o) n_set++;
    if (wel_clr_o) n_clr++;
    if (sr_wr_o) begin n_sr++; last_sr = sr_data_o; end
    if (wr_byte_o) begin wa[n_wr%8] = wr_addr_o; wd[n_wr%8] = wr_data_o; n_wr++; end
    if (wr_commit_o) n_cm++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fall_half(input logic b);
    @(negedge clk_i); sck_i = 1'b0; si_i = b;
    repeat (2) @(negedge clk_i);
  endtask
  task automatic rise_half(output logic r, output logic oe);
    r = so_o; oe = so_oe_o; sck_i = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
    logic r, oe;
    oe_any = 1'b0;
    for (int j = 7; j >= 0; j--) begin
      fall_half(tx[j]); rise_half(r, oe);
      rx[j] = r; oe_any = oe_any | oe;
    end
  endtask
  task automatic cs_lo();
    @(negedge clk_i); sck_i = 1'b0; cs_ni = 1'b0; repeat (2) @(negedge clk_i);
  endtask
  task automatic cs_hi();
    @(negedge clk_i); sck_i = 1'b0; repeat (2) @(negedge clk_i);
    cs_ni = 1'b1; repeat (3) @(negedge clk_i);
  endtask

  // {op, wel, busy, exp_set, exp_clr, exp_oe, 3'b0, exp_rx}
  localparam logic [23:0] VEC [0:10] = '{
    {8'h06, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b0, 8'h00},
    {8'h0E, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'b0, 8'h00},
    {8'h04, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b0, 8'h00},
    {8'h05, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b0, 8'h8A},
    {8'h0D, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'b0, 8'h88},
    {8'h05, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'b0, 8'hFF},
    {8'h06, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b0, 8'h00},
    {8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b0, 8'h00},
    {8'h16, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b0, 8'h00},
    {8'h07, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b0, 8'h00},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b0, 8'h00}
  };

  function automatic string vtag(input int i);
    if (i < 3) return "R2";
    if (i < 5) return "R4";
    if (i < 8) return "R5";
    return "R3";
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rx, rx2, b0, b1, b2;
    logic oe, oe2, r;
    int s0, c0, w0, m0, q0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R1: reset state
    chk("R1 reset oe", so_oe_o, 0);
    chk("R1 reset strobes", n_set + n_clr + n_sr + n_wr + n_cm, 0);

    for (int i = 0; i < 11; i++) begin
      wel_i = VEC[i][15]; busy_i = VEC[i][14];
      s0 = n_set; c0 = n_clr; w0 = n_sr + n_wr + n_cm;
      cs_lo();
      xfer(VEC[i][23:16], rx, oe);
      xfer(8'hA5, rx, oe);
      xfer(8'h5A, rx2, oe2);
      cs_hi();
      chk(vtag(i), n_set - s0, {31'b0, VEC[i][13]});
      chk(vtag(i), n_clr - c0, {31'b0, VEC[i][12]});
      chk(vtag(i), {31'b0, oe | oe2}, {31'b0, VEC[i][11]});
      chk(vtag(i), n_sr + n_wr + n_cm - w0, 0);
      if (VEC[i][11]) begin
        chk(vtag(i), rx, VEC[i][7:0]);
        chk(vtag(i), rx2, VEC[i][7:0]);
      end
    end
    busy_i = 1'b0;

    // R6: read with don't-care high bits and wrap at top
    cs_lo();
    xfer(8'h03, rx, oe); xfer(8'hFF, rx, oe); xfer(8'hFE, rx, oe);
    xfer(8'h00, b0, oe); xfer(8'h00, b1, oe); xfer(8'h00, b2, oe);
    cs_hi();
    chk("R6 byte0", b0, mem_f(14'h3FFE));
    chk("R6 byte1", b1, mem_f(14'h3FFF));
    chk("R6 wrap", b2, mem_f(14'h0000));

    // R10: hold in the middle of an output byte
    cs_lo();
    xfer(8'h03, rx, oe); xfer(8'h00, rx, oe); xfer(8'h10, rx, oe);
    for (int j = 7; j >= 5; j--) begin fall_half(1'b0); rise_half(r, oe); rx[j] = r; end
    fall_half(1'b0);
    hold_ni = 1'b0; repeat (3) @(negedge clk_i);
    chk("R10 oe off in hold", so_oe_o, 0);
    for (int k = 0; k < 2; k++) begin
      sck_i = 1'b1; si_i = 1'b1; repeat (2) @(negedge clk_i);
      sck_i = 1'b0; repeat (2) @(negedge clk_i);
    end
    hold_ni = 1'b1; repeat (3) @(negedge clk_i);
    rise_half(r, oe); rx[4] = r;
    chk("R10 oe back", oe, 1);
    for (int j = 3; j >= 0; j--) begin fall_half(1'b0); rise_half(r, oe); rx[j] = r; end
    cs_hi();
    chk("R10 byte kept", rx, mem_f(14'h0010));

    // R10: hold in the middle of the instruction
    s0 = n_set;
    cs_lo();
    for (int j = 7; j >= 4; j--) begin fall_half(1'b0); rise_half(r, oe); end
    @(negedge clk_i); sck_i = 1'b0; repeat (2) @(negedge clk_i);
    hold_ni = 1'b0; repeat (2) @(negedge clk_i);
    for (int k = 0; k < 2; k++) begin
      si_i = 1'b1; sck_i = 1'b1; repeat (2) @(negedge clk_i);
      sck_i = 1'b0; repeat (2) @(negedge clk_i);
    end
    hold_ni = 1'b1; repeat (2) @(negedge clk_i);
    for (int j = 3; j >= 0; j--) begin fall_half(8'h06 >> j); rise_half(r, oe); end
    cs_hi();
    chk("R10 opcode resumed", n_set - s0, 1);

    // R7/R8: page write across the page end
    wel_i = 1'b1; w0 = n_wr; m0 = n_cm;
    cs_lo();
    xfer(8'h02, rx, oe); xfer(8'h9E, rx, oe); xfer(8'h3F, rx, oe);
    xfer(8'h11, rx, oe); xfer(8'h22, rx, oe);
    cs_hi();
    chk("R7 byte count", n_wr - w0, 2);
    chk("R7 addr0", wa[w0%8], 14'h1E3F);
    chk("R7 data0", wd[w0%8], 8'h11);
    chk("R7 page wrap", wa[(w0+1)%8], 14'h1E20);
    chk("R7 data1", wd[(w0+1)%8], 8'h22);
    chk("R8 commit", n_cm - m0, 1);

    // R8: release off a byte boundary
    w0 = n_wr; m0 = n_cm;
    cs_lo();
    xfer(8'h02, rx, oe); xfer(8'h01, rx, oe); xfer(8'h00, rx, oe); xfer(8'h33, rx, oe);
    for (int j = 0; j < 3; j++) begin fall_half(1'b1); rise_half(r, oe); end
    cs_hi();
    chk("R8 partial byte strobes", n_wr - w0, 1);
    chk("R8 no commit", n_cm - m0, 0);

    // R7: write without latch
    wel_i = 1'b0; w0 = n_wr; m0 = n_cm;
    cs_lo();
    xfer(8'h02, rx, oe); xfer(8'h00, rx, oe); xfer(8'h40, rx, oe); xfer(8'h44, rx, oe);
    cs_hi();
    chk("R7 latch low ignored", n_wr - w0 + n_cm - m0, 0);

    // R9: status write with and without latch
    wel_i = 1'b1; q0 = n_sr;
    cs_lo();
    xfer(8'h01, rx, oe); xfer(8'h8C, rx, oe); xfer(8'h00, rx, oe);
    cs_hi();
    chk("R9 one strobe", n_sr - q0, 1);
    chk("R9 data", last_sr, 8'h8C);
    wel_i = 1'b0; q0 = n_sr;
    cs_lo();
    xfer(8'h01, rx, oe); xfer(8'h0C, rx, oe);
    cs_hi();
    chk("R9 latch low", n_sr - q0, 0);

    // R1: clock activity while deselected
    s0 = n_set + n_clr + n_sr + n_wr + n_cm; oe = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk_i); sck_i = ~sck_i; si_i = 1'b1; oe = oe | so_oe_o;
      @(negedge clk_i); oe = oe | so_oe_o;
    end
    chk("R1 deselected oe", oe, 0);
    chk("R1 deselected strobes", n_set + n_clr + n_sr + n_wr + n_cm - s0, 0);

    finish_run();
  end
endmodule